// File: doc/BRIEF.md
# Reset Supervisor with Request Filter

This block produces the system reset for a chip from two causes: a digital power-fail flag supplied by an external supply comparator, and an active-low reset request pin driven from outside. Its output behaves as an open-drain line: the block only ever pulls the line low or lets go of it, and an external pull-up gives the high level. The output is modelled as a drive-enable plus a pad value that is always zero.

All timing is counted in ticks of a millisecond strobe (`ms_tick`, one clock cycle wide). A power-fail pulls reset low in the same cycle. Once the flag clears, reset stays low for a recovery time. The request pin is first brought into the clock domain by a two-stage synchronizer. It must then stay low for a minimum number of ticks before it is taken as a reset, and after it goes high the reset is held for a release delay.

A request-pin reset behaves like a power cycle. Each time the output goes from released to pulled low, and also at power-up, the block gives a clear strobe. This strobe returns the configuration bits that the package lists (watchdog steering, watchdog multiplier and resolution bits, the alarm and battery-alarm enables, the write and read holds, and the frequency-test enable) to zero. The digital reset `rst_n` stands in for the first application of power.

Top module: `reset_supervisor`

## Requirements
- R1: While `pwr_fail` is 1, `rst_drive_en` is 1 in the same cycle, with no clock edge in between.
- R2: After `pwr_fail` returns to 0, `rst_drive_en` stays 1 through the first RECOVER_MS-1 ticks and drops on the RECOVER_MS-th tick, provided no other cause holds it.
- R3: `rst_pad_o` is 0 at all times, so the pin is only ever pulled low or released (released when `rst_drive_en` is 0).
- R4: A request that stays low (level 0) for fewer than ASSERT_MS ticks causes no reset. A tick that sees the synchronized request high restarts the low-width count from zero.
- R5: A request that stays low for ASSERT_MS ticks makes `rst_drive_en` go to 1 on the ASSERT_MS-th tick.
- R6: Once the request goes high, reset is held through RELEASE_MS-1 ticks and released on the RELEASE_MS-th tick. If the request goes low again during this delay, the reset returns to the held state and the delay starts over.
- R7: `cfg_clear` is 1 for exactly one cycle each time `rst_drive_en` goes from 0 to 1, whether the cause is the pin or a power-fail. It is also 1 while `rst_n` is low.
- R8: The request level is 1 when `req_pin_en` is 0 (pin undriven), whatever `req_pin_n` is. Otherwise it is `req_pin_n`, passed through two synchronizing flip-flops.
- R9: If `pwr_fail` is raised during the release delay of a pin reset, the output is held until the later of the two delays ends. The power recovery count starts again from the moment `pwr_fail` falls.
- R10: After `rst_n` is released, `rst_drive_en` is 1 and is released on the RECOVER_MS-th tick, as after a power-fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the logic |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| pwr_fail | input | 1 | Supply below trip point, active high |
| req_pin_en | input | 1 | 1 when the request pin is driven from outside |
| req_pin_n | input | 1 | Reset request pin level, active low |
| rst_drive_en | output | 1 | 1 = pull the reset pin low, 0 = high impedance |
| rst_pad_o | output | 1 | Value driven on the pin when enabled, always 0 |
| cfg_clear | output | 1 | One-cycle strobe that zeroes the configuration bits |

## Verification
The bench probes the width filter at its edge. A request that stays low for one tick fewer than the minimum, then goes high for one tick and low again, must produce no reset; a design that kept its count across the high gap would reset too early. The bench sends ticks exactly at the assert, release and recovery limits, so an off-by-one counter would release or assert one millisecond off. A pin reset that is re-requested during its release delay must stay held, and a power-fail raised inside that delay must lengthen the hold past the point where the pin delay alone would end. A design that simply OR-ed the two sources without restarting the recovery count would release too soon. An undriven pin held at a low data value must be ignored, and a design that missed this would reset with no request.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    PIN_IDLE    = 2'd0,
    PIN_HOLD    = 2'd1,
    PIN_RELEASE = 2'd2
  } pin_state_t;

  typedef struct packed {
    logic       wd_steer;
    logic [4:0] wd_mult;
    logic [1:0] wd_res;
    logic       alarm_en;
    logic       batt_alarm_en;
    logic       write_hold;
    logic       read_hold;
    logic       freq_test;
  } cfg_bits_t;

  localparam int unsigned CFG_BITS = $bits(cfg_bits_t);

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

  function automatic logic last_tick(input int unsigned count,
                                     input int unsigned limit);
    return (count + 1) >= limit;
  endfunction
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= IDLE_LV;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= IDLE_LV;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsv_req_filter.sv
module rsv_req_filter
  import rsv_pkg::*;
#(
  parameter int unsigned ASSERT_MS  = 50,
  parameter int unsigned RELEASE_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req_sync,
  output logic pin_hold
);
  localparam int unsigned MAXLIM = (ASSERT_MS > RELEASE_MS) ? ASSERT_MS : RELEASE_MS;
  localparam int unsigned CW     = cnt_width(MAXLIM);

  pin_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PIN_IDLE: begin
        if (req_sync) begin
          cnt_d = '0;
        end else if (tick) begin
          if (last_tick(32'(cnt_q), ASSERT_MS)) begin
            state_d = PIN_HOLD;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      PIN_HOLD: begin
        cnt_d = '0;
        if (req_sync) state_d = PIN_RELEASE;
      end
      PIN_RELEASE: begin
        if (!req_sync) begin
          state_d = PIN_HOLD;
          cnt_d   = '0;
        end else if (tick) begin
          if (last_tick(32'(cnt_q), RELEASE_MS)) begin
            state_d = PIN_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = PIN_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PIN_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pin_hold = (state_q != PIN_IDLE);
endmodule

// File: rtl/rsv_pwr_recover.sv
module rsv_pwr_recover
  import rsv_pkg::*;
#(
  parameter int unsigned RECOVER_MS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwr_fail,
  output logic pwr_hold
);
  localparam int unsigned CW = cnt_width(RECOVER_MS);

  logic          hold_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (pwr_fail) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q && tick) begin
      if (last_tick(32'(cnt_q), RECOVER_MS)) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pwr_hold = hold_q;
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import rsv_pkg::*;
#(
  parameter int unsigned ASSERT_MS   = 50,
  parameter int unsigned RELEASE_MS  = 100,
  parameter int unsigned RECOVER_MS  = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic pwr_fail,
  input  logic req_pin_en,
  input  logic req_pin_n,
  output logic rst_drive_en,
  output logic rst_pad_o,
  output logic cfg_clear
);
  logic req_level;
  logic req_sync;
  logic pin_hold;
  logic pwr_hold;
  logic drive_prev_q;

  assign req_level = req_pin_en ? req_pin_n : 1'b1;

  rsv_sync #(
    .STAGES (SYNC_STAGES),
    .IDLE_LV(1'b1)
  ) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (req_level),
    .q    (req_sync)
  );

  rsv_req_filter #(
    .ASSERT_MS (ASSERT_MS),
    .RELEASE_MS(RELEASE_MS)
  ) i_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (ms_tick),
    .req_sync(req_sync),
    .pin_hold(pin_hold)
  );

  rsv_pwr_recover #(
    .RECOVER_MS(RECOVER_MS)
  ) i_recover (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (ms_tick),
    .pwr_fail(pwr_fail),
    .pwr_hold(pwr_hold)
  );

  assign rst_drive_en = pwr_fail | pwr_hold | pin_hold;
  assign rst_pad_o    = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_prev_q <= 1'b0;
    else        drive_prev_q <= rst_drive_en;
  end

  assign cfg_clear = rst_drive_en & ~drive_prev_q;
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker (
  input logic clk,
  input logic rst_n,
  input logic ms_tick,
  input logic pwr_fail,
  input logic req_sync,
  input logic pin_hold,
  input logic pwr_hold,
  input logic rst_drive_en,
  input logic cfg_clear
);
  AST_FAIL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> rst_drive_en); // R1
  AST_FAIL_ARMS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> pwr_hold); // R2
  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_drive_en) |-> $past(ms_tick)); // R2
  AST_PIN_ENTRY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_hold) |-> ($past(ms_tick) && !$past(req_sync))); // R5
  AST_PIN_EXIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_hold) |-> ($past(ms_tick) && $past(req_sync))); // R6
  AST_CLEAR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_drive_en) |-> cfg_clear); // R7
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |=> !cfg_clear); // R7
  AST_CLEAR_ONLY_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |-> rst_drive_en); // R7
endmodule

bind reset_supervisor rsv_checker i_rsv_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .ms_tick     (ms_tick),
  .pwr_fail    (pwr_fail),
  .req_sync    (req_sync),
  .pin_hold    (pin_hold),
  .pwr_hold    (pwr_hold),
  .rst_drive_en(rst_drive_en),
  .cfg_clear   (cfg_clear)
);

// File: tb/test_reset_supervisor.sv
module test_reset_supervisor;
  localparam int unsigned A_MS = 5;
  localparam int unsigned L_MS = 8;
  localparam int unsigned P_MS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic pwr_fail = 1'b0;
  logic req_pin_en = 1'b1;
  logic req_pin_n = 1'b1;
  logic rst_drive_en, rst_pad_o, cfg_clear;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reset_supervisor #(
    .ASSERT_MS (A_MS),
    .RELEASE_MS(L_MS),
    .RECOVER_MS(P_MS)
  ) i_reset_supervisor (
    .clk         (clk),
    .rst_n       (rst_n),
    .ms_tick     (ms_tick),
    .pwr_fail    (pwr_fail),
    .req_pin_en  (req_pin_en),
    .req_pin_n   (req_pin_n),
    .rst_drive_en(rst_drive_en),
    .rst_pad_o   (rst_pad_o),
    .cfg_clear   (cfg_clear)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic set_req(input logic lv);
    @(negedge clk) req_pin_n = lv;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_power_up();
    check("R7", "clear during reset", cfg_clear, 1'b1);
    check("R10", "driven during reset", rst_drive_en, 1'b1);
    check("R3", "pad value", rst_pad_o, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R7", "clear ends after reset", cfg_clear, 1'b0);
    tick(P_MS - 1);
    check("R10", "held before recovery end", rst_drive_en, 1'b1);
    tick(1);
    check("R10", "released at recovery end", rst_drive_en, 1'b0);
  endtask

  task automatic t_power_fail();
    @(negedge clk) pwr_fail = 1'b1;
    #1;
    check("R1", "immediate drive", rst_drive_en, 1'b1);
    check("R7", "clear on power fail", cfg_clear, 1'b1);
    check("R3", "pad value while driven", rst_pad_o, 1'b0);
    @(negedge clk);
    check("R7", "clear one cycle", cfg_clear, 1'b0);
    tick(P_MS + 2);
    check("R1", "held while flag high", rst_drive_en, 1'b1);
    @(negedge clk) pwr_fail = 1'b0;
    tick(P_MS - 1);
    check("R2", "held before recovery end", rst_drive_en, 1'b1);
    tick(1);
    check("R2", "released at recovery end", rst_drive_en, 1'b0);
  endtask

  task automatic t_short_pulse();
    set_req(1'b0);
    tick(A_MS - 1);
    check("R4", "short low no reset", rst_drive_en, 1'b0);
    set_req(1'b1);
    tick(1);
    set_req(1'b0);
    tick(A_MS - 1);
    check("R4", "count restarts after high", rst_drive_en, 1'b0);
    set_req(1'b1);
    tick(2);
    check("R4", "still released", rst_drive_en, 1'b0);
  endtask

  task automatic t_long_pulse();
    set_req(1'b0);
    tick(A_MS - 1);
    check("R5", "not yet driven", rst_drive_en, 1'b0);
    tick(1);
    check("R5", "driven at assert limit", rst_drive_en, 1'b1);
    check("R7", "clear on pin reset", cfg_clear, 1'b1);
    @(negedge clk);
    check("R7", "pin clear one cycle", cfg_clear, 1'b0);
    set_req(1'b1);
    tick(L_MS - 1);
    check("R6", "held in release delay", rst_drive_en, 1'b1);
    set_req(1'b0);
    tick(2);
    check("R6", "re-request holds", rst_drive_en, 1'b1);
    set_req(1'b1);
    tick(L_MS - 1);
    check("R6", "delay restarted", rst_drive_en, 1'b1);
    tick(1);
    check("R6", "released at release limit", rst_drive_en, 1'b0);
  endtask

  task automatic t_undriven();
    @(negedge clk) req_pin_en = 1'b0;
    set_req(1'b0);
    tick(A_MS + 2);
    check("R8", "undriven pin ignored", rst_drive_en, 1'b0);
    set_req(1'b1);
    @(negedge clk) req_pin_en = 1'b1;
  endtask

  task automatic t_fail_in_release();
    set_req(1'b0);
    tick(A_MS);
    check("R9", "pin reset active", rst_drive_en, 1'b1);
    set_req(1'b1);
    tick(2);
    @(negedge clk) pwr_fail = 1'b1;
    tick(1);
    @(negedge clk) pwr_fail = 1'b0;
    tick(P_MS - 1);
    check("R9", "held past pin delay", rst_drive_en, 1'b1);
    tick(1);
    check("R9", "released at recovery end", rst_drive_en, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_power_up();
    t_power_fail();
    t_short_pulse();
    t_long_pulse();
    t_undriven();
    t_fail_in_release();
    check("R3", "pad value at end", rst_pad_o, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule